// File: doc/BRIEF.md
# Masked Alarm Compare Unit

This unit stores an alarm setting for each of the eight calendar and clock fields: hundredths of a second, seconds, minutes, hours, date, month, year and day of week. Each setting has its own ignore flag. On every 100 Hz counter tick, the unit compares each setting whose ignore flag is clear against the matching live counter. When all of those comparisons agree, it issues a single-cycle alarm pulse. A host can therefore build an alarm from any subset of the fields, from "every tick" (all fields ignored) up to one exact instant.

The live counters come in as separate binary buses. The alarm settings are written and read back through a byte-wide register port with a 5-bit address. In each register the field value sits in the low bits and the ignore flag in bit 7. Writes take effect at the clock edge. Reads are combinational on the address. Once all unused bits are removed, the storage is 43 value bits plus 8 ignore bits, which is 51 flops.

Top module: `alarm_compare_unit`

## Requirements
- R1: After a synchronous reset, every alarm register reads 0x80 (ignore flag set, value 0) and `alarm_pulse` is 0.
- R2: The alarm registers sit at addresses 0x08 hundredths, 0x09 seconds, 0x0A minutes, 0x0B hours, 0x0C date, 0x0D month, 0x0E year and 0x0F day of week. Each register keeps its value in the low bits and its ignore flag in bit 7. A write with `reg_wr_en` high stores the byte at the clock edge.
- R3: The value widths are 7, 6, 6, 5, 5, 4, 7 and 3 bits, in the address order of R2. Bits between the value and bit 7 read back as 0, and writes to them are dropped. Read data equals the written byte ANDed with (0x80 | (2^width − 1)).
- R4: Addresses outside 0x08–0x0F read as 0x00. A write to any of them leaves every alarm register unchanged.
- R5: A register whose ignore flag is 1 takes no part in the match. A register whose flag is 0 must equal its live counter. The match is true when every register taking part is equal.
- R6: `alarm_pulse` rises in the cycle after a clock edge at which `tick` is 1 and the match holds. It is 0 in every cycle after an edge at which `tick` was 0, so a match that stays true between ticks does not produce further pulses.
- R7: With all eight ignore flags set, every tick produces a pulse, whatever the live counters are.
- R8: When a register write and a tick land on the same clock edge, the comparison uses the register contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe at each 100 Hz counter advance |
| live_hsec | input | 7 | Live hundredths counter, 0–99 |
| live_sec | input | 6 | Live seconds counter, 0–59 |
| live_min | input | 6 | Live minutes counter, 0–59 |
| live_hour | input | 5 | Live hours counter, 0–23 |
| live_date | input | 5 | Live date counter, 1–31 |
| live_month | input | 4 | Live month counter, 1–12 |
| live_year | input | 7 | Live year counter, 0–99 |
| live_dow | input | 3 | Live day-of-week counter, 0–6 |
| reg_addr | input | 5 | Register address |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| alarm_pulse | output | 1 | One-cycle alarm match pulse |

## Verification
The hardest case to reach from the ports is a write and a tick on the same edge, where the old and new register contents give opposite match results. The bench sets this up by unmasking the seconds register at a value equal to the live counter. It then raises `tick` together with a write of a different seconds value, and expects a pulse on that tick and none on the following tick. The partial-mask behaviour is reached by sweeping every live value of each field with only that field unmasked, and then sweeping the full cross product of the hour and day-of-week fields with both unmasked.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;

    localparam int NUM_FIELDS = 8;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 5;
    localparam int MAX_W      = DATA_W - 1;

    localparam int W_HSEC  = 7;
    localparam int W_SEC   = 6;
    localparam int W_MIN   = 6;
    localparam int W_HOUR  = 5;
    localparam int W_DATE  = 5;
    localparam int W_MONTH = 4;
    localparam int W_YEAR  = 7;
    localparam int W_DOW   = 3;

    // Register order; the day-of-week slot must land on 0x0F
    typedef enum logic [2:0] {
        FLD_HSEC  = 3'd0,
        FLD_SEC   = 3'd1,
        FLD_MIN   = 3'd2,
        FLD_HOUR  = 3'd3,
        FLD_DATE  = 3'd4,
        FLD_MONTH = 3'd5,
        FLD_YEAR  = 3'd6,
        FLD_DOW   = 3'd7
    } field_e;

    typedef struct packed {
        logic             ignore;
        logic [MAX_W-1:0] value;
    } alarm_word_t;

    function automatic int field_width(input int idx);
        case (idx)
            FLD_HSEC:  return W_HSEC;
            FLD_SEC:   return W_SEC;
            FLD_MIN:   return W_MIN;
            FLD_HOUR:  return W_HOUR;
            FLD_DATE:  return W_DATE;
            FLD_MONTH: return W_MONTH;
            FLD_YEAR:  return W_YEAR;
            default:   return W_DOW;
        endcase
    endfunction

    function automatic int total_storage_bits();
        int acc;
        acc = 0;
        for (int i = 0; i < NUM_FIELDS; i++) acc += field_width(i) + 1;
        return acc;
    endfunction

endpackage

// File: rtl/alarm_word_bank.sv
module alarm_word_bank
    import alarm_cmp_pkg::*;
#(
    parameter int BASE_ADDR = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic [DATA_W-1:0]                 rd_data,
    output alarm_word_t [NUM_FIELDS-1:0]      words_o
);

    logic [NUM_FIELDS-1:0] sel;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        localparam int W = field_width(i);

        logic         ign_q;
        logic [W-1:0] val_q;

        assign sel[i] = (addr == ADDR_W'(BASE_ADDR + i));

        always_ff @(posedge clk) begin
            if (rst) begin
                ign_q <= 1'b1;
                val_q <= '0;
            end else if (wr_en && sel[i]) begin
                ign_q <= wr_data[DATA_W-1];
                val_q <= wr_data[W-1:0];
            end
        end

        assign words_o[i].ignore = ign_q;
        assign words_o[i].value  = MAX_W'(val_q);

        // R2: a write to this slot lands in its ignore flag
        p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
            (wr_en && sel[i]) |=> (words_o[i].ignore == $past(wr_data[DATA_W-1])))
            else $error("p_write_lands_r2");
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (sel[i]) rd_data = words_o[i];
        end
    end

    // R4: without a write to a mapped slot the stored words do not move
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (|sel)) |=> $stable(words_o))
        else $error("p_hold_r4");

    // R3: bits between value and ignore flag never read as 1
    p_unused_zero_r3: assert property (@(posedge clk) disable iff (rst)
        sel[FLD_DOW] |-> (rd_data[MAX_W-1:W_DOW] == '0))
        else $error("p_unused_zero_r3");

endmodule

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp
    import alarm_cmp_pkg::*;
(
    input  alarm_word_t       word_i,
    input  logic [MAX_W-1:0]  live_i,
    output logic              hit_o
);

    always_comb begin
        hit_o = word_i.ignore || (word_i.value == live_i);
    end

endmodule

// File: rtl/alarm_match_pulse.sv
module alarm_match_pulse
    import alarm_cmp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick_i,
    input  logic [NUM_FIELDS-1:0] hits_i,
    output logic                  pulse_o
);

    logic match;

    always_comb match = &hits_i;

    always_ff @(posedge clk) begin
        if (rst) pulse_o <= 1'b0;
        else     pulse_o <= tick_i && match;
    end

    // R6: a pulse only follows a tick
    p_pulse_after_tick_r6: assert property (@(posedge clk) disable iff (rst)
        pulse_o |-> $past(tick_i))
        else $error("p_pulse_after_tick_r6");

    // R5: a pulse only follows a full match of the field comparators
    p_pulse_needs_match_r5: assert property (@(posedge clk) disable iff (rst)
        pulse_o |-> $past(&hits_i))
        else $error("p_pulse_needs_match_r5");

    // R7: all comparators agreeing on a tick must give a pulse
    p_tick_match_pulses_r7: assert property (@(posedge clk) disable iff (rst)
        (tick_i && (&hits_i)) |=> pulse_o)
        else $error("p_tick_match_pulses_r7");

endmodule

// File: rtl/alarm_compare_unit.sv
module alarm_compare_unit
    import alarm_cmp_pkg::*;
#(
    parameter int BASE_ADDR = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [W_HSEC-1:0]   live_hsec,
    input  logic [W_SEC-1:0]    live_sec,
    input  logic [W_MIN-1:0]    live_min,
    input  logic [W_HOUR-1:0]   live_hour,
    input  logic [W_DATE-1:0]   live_date,
    input  logic [W_MONTH-1:0]  live_month,
    input  logic [W_YEAR-1:0]   live_year,
    input  logic [W_DOW-1:0]    live_dow,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr_en,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                alarm_pulse
);

    localparam int STORAGE_BITS = total_storage_bits();

    alarm_word_t [NUM_FIELDS-1:0]  words;
    logic [NUM_FIELDS-1:0][MAX_W-1:0] live_vec;
    logic [NUM_FIELDS-1:0]         hits;

    assign live_vec[FLD_HSEC]  = MAX_W'(live_hsec);
    assign live_vec[FLD_SEC]   = MAX_W'(live_sec);
    assign live_vec[FLD_MIN]   = MAX_W'(live_min);
    assign live_vec[FLD_HOUR]  = MAX_W'(live_hour);
    assign live_vec[FLD_DATE]  = MAX_W'(live_date);
    assign live_vec[FLD_MONTH] = MAX_W'(live_month);
    assign live_vec[FLD_YEAR]  = MAX_W'(live_year);
    assign live_vec[FLD_DOW]   = MAX_W'(live_dow);

    alarm_word_bank #(.BASE_ADDR(BASE_ADDR)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wr_data (reg_wdata),
        .rd_data (reg_rdata),
        .words_o (words)
    );

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
        alarm_field_cmp u_cmp (
            .word_i (words[i]),
            .live_i (live_vec[i]),
            .hit_o  (hits[i])
        );
    end

    alarm_match_pulse u_pulse (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .hits_i  (hits),
        .pulse_o (alarm_pulse)
    );

    // R3: storage sums to 51 bits
    initial begin
        p_storage_bits_r3: assert (STORAGE_BITS == 51)
            else $error("p_storage_bits_r3");
    end

    // R1: the cycle after reset the output is quiet
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> !alarm_pulse)
        else $error("p_reset_quiet_r1");

endmodule

// File: tb/sim_alarm_compare_unit.sv
module sim_alarm_compare_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [4:0] reg_addr = '0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       alarm_pulse;
    int         live [8];
    int         n_tests = 0;
    int         n_fail = 0;
    bit         done = 0;

    localparam int FW [8] = '{7, 6, 6, 5, 5, 4, 7, 3};

    always #4 clk = ~clk;

    initial for (int i = 0; i < 8; i++) live[i] = 0;

    alarm_compare_unit u0 (
        .clk(clk), .rst(rst), .tick(tick),
        .live_hsec(7'(live[0])), .live_sec(6'(live[1])), .live_min(6'(live[2])),
        .live_hour(5'(live[3])), .live_date(5'(live[4])), .live_month(4'(live[5])),
        .live_year(7'(live[6])), .live_dow(3'(live[7])),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .alarm_pulse(alarm_pulse)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_addr = 5'(a); reg_wdata = 8'(d); reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input int a, input int exp);
        reg_addr = 5'(a);
        #1;
        check(req, int'(reg_rdata), exp);
    endtask

    task automatic tick_check(input string req, input int exp);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check(req, int'(alarm_pulse), exp);
        @(negedge clk);
        check("R6", int'(alarm_pulse), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset contents
        for (int f = 0; f < 8; f++) rd_check("R1", 8 + f, 8'h80);
        check("R1", int'(alarm_pulse), 0);

        // R7: all ignored -> every tick pulses
        for (int k = 0; k < 4; k++) begin
            for (int f = 0; f < 8; f++) live[f] = (k * 5 + f) % (1 << FW[f]);
            tick_check("R7", 1);
        end

        // R6: no tick, no pulse even though match holds
        repeat (5) begin
            @(negedge clk);
            check("R6", int'(alarm_pulse), 0);
        end

        // R2 / R3: write-readback sweep over every byte and slot
        for (int f = 0; f < 8; f++) begin
            for (int d = 0; d < 256; d++) begin
                wr(8 + f, d);
                rd_check("R3", 8 + f, d & (8'h80 | ((1 << FW[f]) - 1)));
            end
        end
        wr(8'h0F, 8'h05);
        rd_check("R2", 8'h0F, 8'h05);

        // R4: unmapped addresses
        for (int f = 0; f < 8; f++) wr(8 + f, 8'h80 | f);
        for (int a = 0; a < 32; a++) begin
            if (a >= 8 && a < 16) continue;
            wr(a, 8'hFF);
            rd_check("R4", a, 0);
        end
        for (int f = 0; f < 8; f++) rd_check("R4", 8 + f, 8'h80 | f);

        // R5: each field alone unmasked, full live sweep
        for (int f = 0; f < 8; f++) wr(8 + f, 8'h80);
        for (int f = 0; f < 8; f++) begin
            v = (f * 3 + 2) % (1 << FW[f]);
            wr(8 + f, v);
            for (int x = 0; x < (1 << FW[f]); x++) begin
                for (int g = 0; g < 8; g++) if (g != f) live[g] = (x + g) % (1 << FW[g]);
                live[f] = x;
                tick_check("R5", (x == v) ? 1 : 0);
            end
            wr(8 + f, 8'h80);
        end

        // R5: hour and day of week both unmasked
        wr(8'h0B, 5);
        wr(8'h0F, 3);
        for (int h = 0; h < 32; h++) begin
            for (int d = 0; d < 8; d++) begin
                live[3] = h; live[7] = d;
                tick_check("R5", (h == 5 && d == 3) ? 1 : 0);
            end
        end
        wr(8'h0B, 8'h80);
        wr(8'h0F, 8'h80);

        // R8: write and tick on the same edge
        wr(8'h09, 10);
        live[1] = 10;
        @(negedge clk);
        reg_addr = 5'h09; reg_wdata = 8'd20; reg_wr_en = 1'b1; tick = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; tick = 1'b0;
        check("R8", int'(alarm_pulse), 1);
        tick_check("R8", 0);
        live[1] = 20;
        tick_check("R8", 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule